// File: doc/BRIEF.md
# Loadable Asymmetric-Step Up/Down Counter

This block is a fully synchronous 9-bit counter. It moves forward by three or backward by five, loads a parallel value, or holds, as selected by two plain control lines. Every result is registered. Next to the count it keeps three registered flags: an even-parity bit, a wrap-high flag for a forward step that passes the top of the range, and a wrap-low flag for a backward step that passes below zero.

The control encoding is deliberately unusual. With neither line asserted the counter loads. With both asserted it freezes, and that includes all three flags. Arithmetic wraps modulo 2^WIDTH. The counter has no data stream and no back-pressure, so it uses plain level-sampled pins instead of a valid/ready handshake. The step sizes and the width are parameters. The default is a 9-bit counter with steps of +3 and -5.

Top module: `stepctr`

## Requirements
- R1: With `fwd_i`=1 and `rev_i`=0, on the rising edge `value_o` becomes its previous value plus 3, modulo 512.
- R2: With `fwd_i`=0 and `rev_i`=1, on the rising edge `value_o` becomes its previous value minus 5, modulo 512.
- R3: With `fwd_i`=0 and `rev_i`=0, on the rising edge `value_o` takes `seed_i`, and `wrap_hi_o` and `wrap_lo_o` both become 0.
- R4: With `fwd_i`=1 and `rev_i`=1, `value_o`, `par_o`, `wrap_hi_o` and `wrap_lo_o` keep their values, whatever `seed_i` is.
- R5: `par_o` always equals the XOR of the 9 bits of `value_o`, so the ten bits together hold an even number of ones. It changes on the same edge as the count.
- R6: After a forward step, `wrap_hi_o` is 1 exactly when the previous count was 509, 510 or 511, and 0 otherwise. It lasts one cycle unless the next cycle is a hold.
- R7: After a backward step, `wrap_lo_o` is 1 exactly when the previous count was 0 to 4, and 0 otherwise. The two wrap flags are never 1 together.
- R8: A synchronous active-high `srst` sampled at a rising edge sets `value_o`, `par_o`, `wrap_hi_o` and `wrap_lo_o` to 0.
- R9: Outputs change only at a rising clock edge. A change of inputs between edges does not alter the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| fwd_i | input | 1 | Forward-step select (see encoding in R1-style rules) |
| rev_i | input | 1 | Backward-step select |
| seed_i | input | 9 | Parallel load value |
| value_o | output | 9 | Registered count |
| par_o | output | 1 | Registered even-parity bit of the count |
| wrap_hi_o | output | 1 | Registered flag: last forward step wrapped past the top |
| wrap_lo_o | output | 1 | Registered flag: last backward step wrapped below zero |

## Verification
Every result (the count, the parity bit and both wrap flags) is due exactly one rising edge after the controls and the seed are presented. The bench drives inputs at a falling edge. It compares the outputs a nanosecond later, when they must still show the previous state, and again at the following falling edge, when they must show the new state. The expected state comes from a bench-side model that advances once per rising edge. The directed tasks visit the wrap boundaries 509–511 going forward and 0–4 going backward, together with their first non-wrapping neighbours.

// File: rtl/stepctr_pkg.sv
`timescale 1ns/1ps
package stepctr_pkg;
  localparam int CTR_W_DEF   = 9;
  localparam int FWD_STEP_DEF = 3;
  localparam int REV_STEP_DEF = 5;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_ADD  = 2'b01,
    MODE_SUB  = 2'b10,
    MODE_HOLD = 2'b11
  } step_mode_e;
endpackage

// File: rtl/stepctr_decode.sv
`timescale 1ns/1ps
module stepctr_decode
  import stepctr_pkg::*;
(
  input  logic       fwd_i,
  input  logic       rev_i,
  output step_mode_e mode_o
);
  always_comb begin
    unique case ({rev_i, fwd_i})
      2'b00:   mode_o = MODE_LOAD;
      2'b01:   mode_o = MODE_ADD;
      2'b10:   mode_o = MODE_SUB;
      default: mode_o = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/stepctr_arith.sv
`timescale 1ns/1ps
module stepctr_arith
  import stepctr_pkg::*;
#(
  parameter int WIDTH    = CTR_W_DEF,
  parameter int FWD_STEP = FWD_STEP_DEF,
  parameter int REV_STEP = REV_STEP_DEF
) (
  input  step_mode_e       mode_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             nxt_hi_o,
  output logic             nxt_lo_o,
  output logic             upd_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] sum_ext;
  logic [EXT_W-1:0] dif_ext;

  // Separate add and subtract paths; the extra MSB is the carry / borrow out.
  assign sum_ext = {1'b0, cur_i} + EXT_W'(FWD_STEP);
  assign dif_ext = {1'b0, cur_i} - EXT_W'(REV_STEP);

  always_comb begin
    nxt_o    = cur_i;
    nxt_hi_o = 1'b0;
    nxt_lo_o = 1'b0;
    upd_o    = 1'b1;
    unique case (mode_i)
      MODE_ADD: begin
        nxt_o    = sum_ext[WIDTH-1:0];
        nxt_hi_o = sum_ext[WIDTH];
      end
      MODE_SUB: begin
        nxt_o    = dif_ext[WIDTH-1:0];
        nxt_lo_o = dif_ext[WIDTH];
      end
      MODE_LOAD: begin
        nxt_o    = seed_i;
      end
      default: begin
        upd_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/stepctr_parity.sv
`timescale 1ns/1ps
module stepctr_parity #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             par_o
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap-ordered binary XOR tree; node 0 is the root.
  logic [NODES-1:0] node;

  for (genvar li = 0; li < LEAVES; li++) begin : g_leaf
    if (li < WIDTH) begin : g_bit
      assign node[LEAVES-1+li] = data_i[li];
    end else begin : g_pad
      assign node[LEAVES-1+li] = 1'b0;
    end
  end

  for (genvar ni = 0; ni < LEAVES - 1; ni++) begin : g_inner
    assign node[ni] = node[2*ni+1] ^ node[2*ni+2];
  end

  assign par_o = node[0];
endmodule

// File: rtl/stepctr.sv
`timescale 1ns/1ps
module stepctr
  import stepctr_pkg::*;
#(
  parameter int WIDTH    = CTR_W_DEF,
  parameter int FWD_STEP = FWD_STEP_DEF,
  parameter int REV_STEP = REV_STEP_DEF
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             fwd_i,
  input  logic             rev_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] value_o,
  output logic             par_o,
  output logic             wrap_hi_o,
  output logic             wrap_lo_o
);
  step_mode_e       mode;
  logic [WIDTH-1:0] nxt_val;
  logic             nxt_hi;
  logic             nxt_lo;
  logic             upd;
  logic             nxt_par;

  stepctr_decode u_decode (
    .fwd_i  (fwd_i),
    .rev_i  (rev_i),
    .mode_o (mode)
  );

  stepctr_arith #(
    .WIDTH    (WIDTH),
    .FWD_STEP (FWD_STEP),
    .REV_STEP (REV_STEP)
  ) u_arith (
    .mode_i   (mode),
    .cur_i    (value_o),
    .seed_i   (seed_i),
    .nxt_o    (nxt_val),
    .nxt_hi_o (nxt_hi),
    .nxt_lo_o (nxt_lo),
    .upd_o    (upd)
  );

  stepctr_parity #(.WIDTH(WIDTH)) u_parity (
    .data_i (nxt_val),
    .par_o  (nxt_par)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      value_o   <= '0;
      par_o     <= 1'b0;
      wrap_hi_o <= 1'b0;
      wrap_lo_o <= 1'b0;
    end else if (upd) begin
      value_o   <= nxt_val;
      par_o     <= nxt_par;
      wrap_hi_o <= nxt_hi;
      wrap_lo_o <= nxt_lo;
    end
  end
endmodule

// File: rtl/stepctr_chk.sv
`timescale 1ns/1ps
module stepctr_chk #(
  parameter int WIDTH    = 9,
  parameter int FWD_STEP = 3,
  parameter int REV_STEP = 5
) (
  input logic             clk,
  input logic             srst,
  input logic             fwd_i,
  input logic             rev_i,
  input logic [WIDTH-1:0] seed_i,
  input logic [WIDTH-1:0] value_o,
  input logic             par_o,
  input logic             wrap_hi_o,
  input logic             wrap_lo_o
);
  localparam logic [WIDTH-1:0] TOP_V  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] HI_LIM = TOP_V - WIDTH'(FWD_STEP);
  localparam logic [WIDTH-1:0] LO_LIM = WIDTH'(REV_STEP);

  // R1
  fwd_step_chk: assert property (@(posedge clk) disable iff (srst)
    (fwd_i && !rev_i) |=> value_o == WIDTH'($past(value_o) + WIDTH'(FWD_STEP)));

  // R2
  rev_step_chk: assert property (@(posedge clk) disable iff (srst)
    (rev_i && !fwd_i) |=> value_o == WIDTH'($past(value_o) - WIDTH'(REV_STEP)));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (srst)
    (!fwd_i && !rev_i) |=> (value_o == $past(seed_i)) && !wrap_hi_o && !wrap_lo_o);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (srst)
    (fwd_i && rev_i) |=> $stable(value_o) && $stable(par_o)
                         && $stable(wrap_hi_o) && $stable(wrap_lo_o));

  // R5
  even_ones_chk: assert property (@(posedge clk) disable iff (srst)
    ($countones({value_o, par_o}) % 2) == 0);

  // R6
  wrap_hi_chk: assert property (@(posedge clk) disable iff (srst)
    (fwd_i && !rev_i) |=> wrap_hi_o == ($past(value_o) > HI_LIM));

  // R7
  wrap_lo_chk: assert property (@(posedge clk) disable iff (srst)
    (rev_i && !fwd_i) |=> wrap_lo_o == ($past(value_o) < LO_LIM));

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (srst)
    !(wrap_hi_o && wrap_lo_o));

  // R8
  reset_chk: assert property (@(posedge clk)
    srst |=> (value_o == '0) && !par_o && !wrap_hi_o && !wrap_lo_o);
endmodule

bind stepctr stepctr_chk #(
  .WIDTH    (WIDTH),
  .FWD_STEP (FWD_STEP),
  .REV_STEP (REV_STEP)
) u_chk (
  .clk       (clk),
  .srst      (srst),
  .fwd_i     (fwd_i),
  .rev_i     (rev_i),
  .seed_i    (seed_i),
  .value_o   (value_o),
  .par_o     (par_o),
  .wrap_hi_o (wrap_hi_o),
  .wrap_lo_o (wrap_lo_o)
);

// File: tb/stepctr_bench.sv
`timescale 1ns/1ps
module stepctr_bench;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         srst = 1'b1;
  logic         fwd_i = 1'b0;
  logic         rev_i = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic [W-1:0] value_o;
  logic         par_o;
  logic         wrap_hi_o;
  logic         wrap_lo_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] m_val = '0;
  logic         m_par = 1'b0;
  logic         m_hi  = 1'b0;
  logic         m_lo  = 1'b0;

  always #2 clk = ~clk;

  stepctr u_stepctr (
    .clk       (clk),
    .srst      (srst),
    .fwd_i     (fwd_i),
    .rev_i     (rev_i),
    .seed_i    (seed_i),
    .value_o   (value_o),
    .par_o     (par_o),
    .wrap_hi_o (wrap_hi_o),
    .wrap_lo_o (wrap_lo_o)
  );

  task automatic verify(input string tag);
    n_chk++;
    if (value_o !== m_val || par_o !== m_par || wrap_hi_o !== m_hi || wrap_lo_o !== m_lo) begin
      n_fail++;
      $display("FAIL %s: got val=%0d par=%0b hi=%0b lo=%0b, expected val=%0d par=%0b hi=%0b lo=%0b",
               tag, value_o, par_o, wrap_hi_o, wrap_lo_o, m_val, m_par, m_hi, m_lo);
    end
  endtask

  // Called at a falling edge: drive, confirm nothing moved (R9), advance model at the edge, check.
  task automatic apply(input logic f, input logic r, input logic [W-1:0] s, input string tag);
    logic [W:0] ext;
    fwd_i = f; rev_i = r; seed_i = s;
    #1 verify("R9");
    @(posedge clk);
    if (srst) begin
      m_val = '0; m_hi = 1'b0; m_lo = 1'b0;
    end else begin
      unique case ({r, f})
        2'b00: begin m_val = s; m_hi = 1'b0; m_lo = 1'b0; end
        2'b01: begin ext = {1'b0, m_val} + 10'd3; m_val = ext[W-1:0]; m_hi = ext[W]; m_lo = 1'b0; end
        2'b10: begin m_lo = (m_val < 9'd5); m_val = m_val - 9'd5; m_hi = 1'b0; end
        default: ;
      endcase
    end
    m_par = ^m_val;
    @(negedge clk);
    verify(tag);
  endtask

  task automatic t_reset();
    srst = 1'b1;
    apply(1'b0, 1'b0, 9'h1FF, "R8");
    srst = 1'b0;
  endtask

  task automatic t_load();
    apply(1'b0, 1'b0, 9'h1A5, "R3");
    apply(1'b0, 1'b0, 9'd7, "R3");
  endtask

  task automatic t_up();
    apply(1'b0, 1'b0, 9'd100, "R3");
    for (int i = 0; i < 4; i++) apply(1'b1, 1'b0, 9'h0AA, "R1");
  endtask

  task automatic t_down();
    apply(1'b0, 1'b0, 9'd300, "R3");
    for (int i = 0; i < 4; i++) apply(1'b0, 1'b1, 9'h155, "R2");
  endtask

  task automatic t_hold();
    apply(1'b0, 1'b0, 9'd77, "R3");
    apply(1'b1, 1'b1, 9'd0, "R4");
    apply(1'b1, 1'b1, 9'h1FF, "R4");
    apply(1'b0, 1'b0, 9'd510, "R3");
    apply(1'b1, 1'b0, 9'd0, "R6");
    apply(1'b1, 1'b1, 9'd3, "R4");
    apply(1'b1, 1'b1, 9'd9, "R4");
  endtask

  task automatic t_wrap_up();
    for (int v = 506; v < 512; v++) begin
      apply(1'b0, 1'b0, 9'(v), "R3");
      apply(1'b1, 1'b0, 9'd0, "R6");
      apply(1'b1, 1'b0, 9'd0, "R6");
    end
  endtask

  task automatic t_wrap_down();
    for (int v = 0; v < 7; v++) begin
      apply(1'b0, 1'b0, 9'(v), "R3");
      apply(1'b0, 1'b1, 9'd0, "R7");
      apply(1'b0, 1'b1, 9'd0, "R7");
    end
  endtask

  task automatic t_parity();
    apply(1'b0, 1'b0, 9'h000, "R5");
    apply(1'b0, 1'b0, 9'h001, "R5");
    apply(1'b0, 1'b0, 9'h1FF, "R5");
    apply(1'b0, 1'b0, 9'h100, "R5");
    for (int i = 0; i < 20; i++) apply(1'b1, 1'b0, 9'd0, "R5");
    for (int i = 0; i < 20; i++) apply(1'b0, 1'b1, 9'd0, "R5");
  endtask

  task automatic t_reset_mid();
    apply(1'b0, 1'b0, 9'd333, "R3");
    srst = 1'b1;
    apply(1'b1, 1'b0, 9'd0, "R8");
    srst = 1'b0;
    apply(1'b0, 1'b1, 9'd0, "R7");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    t_reset();
    t_load();
    t_up();
    t_down();
    t_hold();
    t_wrap_up();
    t_wrap_down();
    t_parity();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule